// File: doc/BRIEF.md
# Mersenne Primality Tester (Lucas-Lehmer)

This block decides whether the Mersenne number 2^p − 1 is prime. An exponent is placed on the `exponent` input and `start` is pulsed. The block then seeds a residue with 4 and repeats one step p − 2 times. Each step squares the residue modulo 2^p − 1 and subtracts 2. When the steps are done, the residue is compared with zero. A single-cycle `done` strobe then marks the verdict on `isPrime`.

The block never divides. It squares serially, taking one multiplier bit per clock. For each bit, the residue is rotated within p bits, so the bits that pass position p fold back to the bottom, and the result is summed by an adder with end-around carry. Each finished residue is shown on `residue` with a one-cycle `stepValid` strobe, so a host or a trace can follow the sequence. A control FSM sequences the bit counter and the step counter. A separate datapath holds the mask, the residue and the accumulator.

Top module: `ll_mersenne_tester`

## Requirements
- R1: After reset, `done`, `stepValid` and `isPrime` are all 0.
- R2: For 3 ≤ p ≤ RES_W, a start seeds the residue with 4. The block then emits exactly p − 2 residues, each flagged by a one-cycle `stepValid`. Each residue is (S·S − 2) mod (2^p − 1) of the previous value S. For p = 7 the residues are 14, 67, 42, 111, 0.
- R3: Every emitted residue lies in the canonical range 0 to 2^p − 2. The all-ones value is never produced and reads as zero.
- R4: The subtract stage wraps modulo 2^p − 1. A squared value of 0 gives 2^p − 3, and a squared value of 1 gives 2^p − 2.
- R5: For 3 ≤ p ≤ RES_W, `done` is high for exactly one cycle, one cycle after the last residue. `isPrime` is 1 exactly when that last residue is 0. For example, p = 7 gives 1 and p = 11 gives 0.
- R6: For p = 0, 1 or 2, no residue is emitted. `done` pulses with `isPrime` = 1 for p = 2 and 0 for p = 0 or 1.
- R7: For p > RES_W, no residue is emitted, and `done` pulses with `isPrime` = 0.
- R8: A `start` that arrives while a run is in progress is ignored. The running sequence, its verdict and its mask are not disturbed.
- R9: `isPrime` changes only in the cycle in which `done` is high, and it holds until the next run reports.
- R10: Consecutive residues of one run appear exactly p + 1 cycles apart: p multiplier-bit cycles plus one subtract cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when the block is idle |
| exponent | input | EXP_W | Exponent p, sampled with an accepted start |
| done | output | 1 | One-cycle strobe: verdict valid |
| isPrime | output | 1 | 1 when 2^p − 1 is prime, held between runs |
| stepValid | output | 1 | One-cycle strobe: a new residue is on `residue` |
| residue | output | RES_W | Current residue of the sequence |

## Verification
The bench builds the block with its default widths: a 16-bit residue and a 16-bit exponent. It sweeps every exponent from 0 to 17, which covers each mask width the datapath can hold. At p = 16 the end-around carry leaves from the top bit of the adder. The range also includes the short exponents below 3 and one exponent just past the datapath. Extra starts are injected during a long run and during the one-cycle path of a short run. These show that a busy block ignores them.

// File: rtl/ll_pkg.sv
package ll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_SUB,
    ST_FIN
  } ll_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // seed residue, latch mask
    logic mulStep;  // accumulate one partial product
    logic subStep;  // commit square minus two
  } ll_ctl_t;

endpackage

// File: rtl/ll_mod_add.sv
// Adder modulo 2^p-1: bits above the mask re-enter as carry-in,
// and an all-ones sum is mapped to zero.
module ll_mod_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] mask,
  output logic [W-1:0] sumOut
);

  logic [W:0]   rawSum;
  logic [W:0]   highBits;
  logic         wrapCarry;
  logic [W-1:0] lowBits;
  logic [W-1:0] folded;

  always_comb begin
    rawSum    = {1'b0, opA} + {1'b0, opB};
    highBits  = rawSum & ~{1'b0, mask};
    wrapCarry = |highBits;
    lowBits   = rawSum[W-1:0] & mask;
    folded    = lowBits + W'(wrapCarry);
    sumOut    = (folded == mask) ? '0 : folded;
  end

endmodule

// File: rtl/ll_pp_gen.sv
// Partial product for multiplier bit idx: the multiplicand rotated left
// by idx inside p bits, or zero when the selected multiplier bit is clear.
module ll_pp_gen #(
  parameter int W    = 16,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    multiplicand,
  input  logic            selBit,
  input  logic [SH_W-1:0] idx,
  input  logic [SH_W-1:0] pVal,
  input  logic [W-1:0]    mask,
  output logic [W-1:0]    ppOut
);

  logic [W-1:0] upper;
  logic [W-1:0] wrapped;

  always_comb begin
    upper   = (multiplicand << idx) & mask;
    wrapped = multiplicand >> (pVal - idx);
    ppOut   = selBit ? (upper | wrapped) : '0;
  end

endmodule

// File: rtl/ll_datapath.sv
module ll_datapath
  import ll_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ll_ctl_t          ctl,
  input  logic [SH_W-1:0]  bitIdx,
  input  logic [SH_W-1:0]  pVal,
  input  logic [SH_W-1:0]  expLow,
  output logic [RES_W-1:0] residue,
  output logic [RES_W-1:0] maskOut,
  output logic             stepValid,
  output logic             resIsZero
);

  logic [RES_W-1:0] maskReg;
  logic [RES_W-1:0] accReg;
  logic [RES_W-1:0] ppTerm;
  logic [RES_W-1:0] accNext;
  logic [RES_W-1:0] subVal;
  logic [RES_W-1:0] resShifted;
  logic [RES_W:0]   maskWide;
  logic             xBit;

  assign maskWide   = ((RES_W + 1)'(1) << expLow) - (RES_W + 1)'(1);
  assign resShifted = residue >> bitIdx;
  assign xBit       = resShifted[0];

  ll_pp_gen #(.W(RES_W), .SH_W(SH_W)) ppGen_i (
    .multiplicand(residue),
    .selBit      (xBit),
    .idx         (bitIdx),
    .pVal        (pVal),
    .mask        (maskReg),
    .ppOut       (ppTerm)
  );

  ll_mod_add #(.W(RES_W)) modAdd_i (
    .opA   (accReg),
    .opB   (ppTerm),
    .mask  (maskReg),
    .sumOut(accNext)
  );

  // square minus two, wrapping below zero by adding the modulus
  assign subVal = (accReg >= RES_W'(2)) ? (accReg - RES_W'(2))
                                        : (maskReg - RES_W'(2) + accReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg   <= '0;
      residue   <= '0;
      accReg    <= '0;
      stepValid <= 1'b0;
    end else begin
      stepValid <= ctl.subStep;
      if (ctl.load) begin
        maskReg <= maskWide[RES_W-1:0];
        residue <= RES_W'(4);
        accReg  <= '0;
      end else if (ctl.mulStep) begin
        accReg <= accNext;
      end else if (ctl.subStep) begin
        residue <= subVal;
        accReg  <= '0;
      end
    end
  end

  assign maskOut   = maskReg;
  assign resIsZero = (residue == '0);

endmodule

// File: rtl/ll_control.sv
module ll_control
  import ll_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int EXP_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EXP_W-1:0] expIn,
  input  logic             resIsZero,
  output ll_ctl_t          ctl,
  output logic [SH_W-1:0]  bitIdx,
  output logic [SH_W-1:0]  pVal,
  output logic             busy,
  output logic             done,
  output logic             isPrime
);

  ll_state_e       state;
  logic [SH_W-1:0] pReg;
  logic [SH_W-1:0] bitIdxQ;
  logic [SH_W-1:0] iterLeft;
  logic            shortRun;
  logic            shortVerdict;
  logic            inRange;

  assign inRange = (expIn >= EXP_W'(3)) && (expIn <= EXP_W'(RES_W));

  always_comb begin
    ctl.load    = start && (state == ST_IDLE) && inRange;
    ctl.mulStep = (state == ST_MUL);
    ctl.subStep = (state == ST_SUB);
  end

  assign busy   = (state != ST_IDLE);
  assign bitIdx = bitIdxQ;
  assign pVal   = pReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pReg         <= '0;
      bitIdxQ      <= '0;
      iterLeft     <= '0;
      shortRun     <= 1'b0;
      shortVerdict <= 1'b0;
      done         <= 1'b0;
      isPrime      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pReg    <= expIn[SH_W-1:0];
            bitIdxQ <= '0;
            if (inRange) begin
              iterLeft <= expIn[SH_W-1:0] - SH_W'(2);
              shortRun <= 1'b0;
              state    <= ST_MUL;
            end else begin
              shortRun     <= 1'b1;
              shortVerdict <= (expIn == EXP_W'(2));
              state        <= ST_FIN;
            end
          end
        end
        ST_MUL: begin
          bitIdxQ <= bitIdxQ + SH_W'(1);
          if (bitIdxQ == pReg - SH_W'(1)) state <= ST_SUB;
        end
        ST_SUB: begin
          bitIdxQ  <= '0;
          iterLeft <= iterLeft - SH_W'(1);
          state    <= (iterLeft == SH_W'(1)) ? ST_FIN : ST_MUL;
        end
        ST_FIN: begin
          done    <= 1'b1;
          isPrime <= shortRun ? shortVerdict : resIsZero;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ll_mersenne_tester.sv
module ll_mersenne_tester
  import ll_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EXP_W-1:0] exponent,
  output logic             done,
  output logic             isPrime,
  output logic             stepValid,
  output logic [RES_W-1:0] residue
);

  localparam int SH_W = $clog2(RES_W + 1);

  ll_ctl_t          ctl;
  logic [SH_W-1:0]  bitIdx;
  logic [SH_W-1:0]  pVal;
  logic             resIsZero;
  logic             busy;
  logic [RES_W-1:0] activeMask;

  ll_control #(.RES_W(RES_W), .EXP_W(EXP_W), .SH_W(SH_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .expIn    (exponent),
    .resIsZero(resIsZero),
    .ctl      (ctl),
    .bitIdx   (bitIdx),
    .pVal     (pVal),
    .busy     (busy),
    .done     (done),
    .isPrime  (isPrime)
  );

  ll_datapath #(.RES_W(RES_W), .SH_W(SH_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .bitIdx   (bitIdx),
    .pVal     (pVal),
    .expLow   (exponent[SH_W-1:0]),
    .residue  (residue),
    .maskOut  (activeMask),
    .stepValid(stepValid),
    .resIsZero(resIsZero)
  );

endmodule

// File: rtl/ll_mersenne_checker.sv
module ll_mersenne_checker #(
  parameter int RES_W = 16,
  parameter int EXP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [EXP_W-1:0] exponent,
  input logic             done,
  input logic             isPrime,
  input logic             stepValid,
  input logic [RES_W-1:0] residue,
  input logic             busy,
  input logic [RES_W-1:0] activeMask
);

  logic [EXP_W-1:0] stepCnt;
  logic [EXP_W-1:0] expSteps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt  <= '0;
      expSteps <= '0;
    end else if (start && !busy) begin
      stepCnt  <= '0;
      expSteps <= (exponent >= EXP_W'(3) && exponent <= EXP_W'(RES_W))
                  ? exponent - EXP_W'(2) : '0;
    end else if (stepValid) begin
      stepCnt <= stepCnt + EXP_W'(1);
    end
  end

  // R3
  residue_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepValid |-> (residue < activeMask));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2 (also R6, R7: zero steps for short and oversize exponents)
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stepCnt == expSteps));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(activeMask));

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(isPrime) |-> done);

endmodule

bind ll_mersenne_tester ll_mersenne_checker #(.RES_W(RES_W), .EXP_W(EXP_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .exponent  (exponent),
  .done      (done),
  .isPrime   (isPrime),
  .stepValid (stepValid),
  .residue   (residue),
  .busy      (busy),
  .activeMask(activeMask)
);

// File: tb/ll_mersenne_tester_tb_top.sv
module ll_mersenne_tester_tb_top;

  localparam int RES_W = 16;
  localparam int EXP_W = 16;

  typedef struct {
    bit     isVerdict;
    longint val;
    string  req;
  } exp_item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [EXP_W-1:0] exponent = '0;
  logic             done;
  logic             isPrime;
  logic             stepValid;
  logic [RES_W-1:0] residue;

  exp_item_t expQ[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lastStepCyc = 0;
  int stepsSeen = 0;
  int curP = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ll_mersenne_tester #(.RES_W(RES_W), .EXP_W(EXP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exponent(exponent),
    .done(done), .isPrime(isPrime), .stepValid(stepValid), .residue(residue)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: compute the expected sequence, push it, launch the run
  task automatic runOne(input int p, input int pokeAt);
    longint m;
    longint s;
    exp_item_t it;
    if (p >= 3 && p <= RES_W) begin
      m = (longint'(1) << p) - 1;
      s = 4;
      for (int k = 0; k < p - 2; k++) begin
        s = (s * s + m - 2) % m;
        it.isVerdict = 0; it.val = s; it.req = "R2";
        expQ.push_back(it);
      end
      it.isVerdict = 1; it.val = (s == 0) ? 1 : 0; it.req = "R5";
    end else begin
      it.isVerdict = 1; it.val = (p == 2) ? 1 : 0;
      it.req = (p > RES_W) ? "R7" : "R6";
    end
    expQ.push_back(it);
    curP = p;
    stepsSeen = 0;
    @(negedge clk);
    exponent = EXP_W'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeAt >= 0) begin
      repeat (pokeAt) @(negedge clk);
      exponent = EXP_W'(5);   // R8: start during a run must be ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R9: verdict held, no further strobes
    check(isPrime == 1'(it.val), "R9 hold", longint'(isPrime), it.val);
    check(!done && !stepValid, "R8 quiet after run", longint'({done, stepValid}), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (stepValid) begin
        if (stepsSeen > 0)
          check(cyc - lastStepCyc == curP + 1, "R10 step spacing",
                cyc - lastStepCyc, curP + 1);
        stepsSeen++;
        lastStepCyc = cyc;
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected residue", residue, -1);
        end else begin
          exp_item_t e;
          e = expQ.pop_front();
          check(!e.isVerdict && residue == RES_W'(e.val),
                {e.req, " R3 R4 residue"}, residue, e.val);
        end
      end
      if (done) begin
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected done", isPrime, -1);
        end else begin
          exp_item_t e;
          e = expQ.pop_front();
          check(e.isVerdict && isPrime == 1'(e.val), {e.req, " verdict"},
                isPrime, e.val);
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!done && !stepValid && !isPrime, "R1 reset",
          longint'({done, stepValid, isPrime}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !stepValid && !isPrime, "R1 after release",
          longint'({done, stepValid, isPrime}), 0);
    runOne(7, -1);
    runOne(11, 20);
    runOne(2, 0);
    for (int p = 0; p <= RES_W + 1; p++) runOne(p, -1);
    runOne(13, 3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule